// File: doc/BRIEF.md
# Inter-Core Interrupt Unit

This block lets the cores of a small cluster (up to four cores by default) signal each other. Every core reaches the unit through one shared command port. A command carries an opcode, a core-index parameter and the index of the core that issues it. The unit keeps one pending flag for each ordered pair of sender and target. It drives one interrupt line per core, and that line is the OR of all flags aimed at that core.

A core that receives an interrupt does not get a per-sender line. It asks the unit which cores are waiting on it, and receives the answer as a bitmap. It then acknowledges each sender on its own. A sender can first ask whether its previous request to a target is still outstanding, and skip a redundant one. Requests from several cores to one target merge onto that target's single line, so the bitmap may hold more than one set bit. A repeated request from the same sender to the same target merges into the flag that is already set.

Read-type commands return their answer in a readback register. The answer appears on the cycle after the command. The register keeps that value until the next read-type command.

Top module: `xirq_unit`

## Requirements
- R1: A valid generate command (opcode 0) whose parameter names a core other than the issuer sets the flag from the issuer to that target. The target's `irq_out` bit is high from the cycle after the command.
- R2: A generate command whose parameter equals the issuing core changes no flag and no interrupt line.
- R3: A generate command to a target that already has a flag set from the same sender leaves the state unchanged. One acknowledge then clears it, and no second event remains.
- R4: A valid read-status command (opcode 1) loads the readback register with a value whose bit 0 is the flag from the issuer to the target named by the parameter. All other bits are zero. The value is visible from the cycle after the command.
- R5: A valid check-source command (opcode 2) loads the readback register with a bitmap whose bit s is set exactly when core s has a flag pending toward the issuer. All bits above the core count are zero. More than one bit may be set.
- R6: A valid acknowledge command (opcode 3) clears only the flag from the sender named by the parameter to the issuing core. Every other flag is left unchanged.
- R7: `irq_out[t]` is high exactly when at least one flag toward core t is set. It stays high until every such flag has been acknowledged.
- R8: The readback register holds its value across generate commands, acknowledge commands and cycles with `cmd_valid` low.
- R9: After reset, every flag is clear, `irq_out` is all zero and the readback register is zero.
- R10: A command presented with `cmd_valid` low changes nothing. Commands are applied one per cycle, in order of arrival.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command present this cycle |
| cmd_op | input | 2 | 0 generate, 1 read status, 2 check source, 3 acknowledge |
| cmd_param | input | IDX_W (2) | Target core (generate, read status) or sender core (acknowledge) |
| cmd_core | input | IDX_W (2) | Index of the issuing core |
| readback | output | RB_W (32) | Result of the last read-type command |
| irq_out | output | NUM_CORES (4) | One interrupt line per core |

## Verification
A seeded random stream mixes all four opcodes, idle cycles and self-targeted generates. A flag model follows each command and tells a wrong flag update apart from a wrong readback. Directed sequences cover the merge cases:
- a repeated generate from one sender, which must leave a single flag that one acknowledge clears;
- two senders to one target, which must show two bits in the source bitmap and keep the line high until the second acknowledge;
- a self-targeted generate, which must change nothing.

A command held with `cmd_valid` low, followed at once by a line and readback check, separates a decoder that ignores the valid qualifier from a correct one.

// File: rtl/xirq_pkg.sv
package xirq_pkg;
  localparam int OP_W = 2;

  typedef enum logic [OP_W-1:0] {
    OP_RAISE = 2'd0,
    OP_PEEK  = 2'd1,
    OP_WHO   = 2'd2,
    OP_CLEAR = 2'd3
  } xirq_op_e;
endpackage

// File: rtl/xirq_decode.sv
module xirq_decode #(
  parameter int NUM_CORES = 4,
  parameter int IDX_W     = 2
) (
  input  logic                                cmd_valid,
  input  logic [1:0]                          cmd_op,
  input  logic [IDX_W-1:0]                    cmd_param,
  input  logic [IDX_W-1:0]                    cmd_core,
  output logic [NUM_CORES-1:0][NUM_CORES-1:0] set_mx,
  output logic [NUM_CORES-1:0][NUM_CORES-1:0] clr_mx,
  output logic                                rd_peek,
  output logic                                rd_who,
  output logic                                self_hit
);
  import xirq_pkg::*;

  function automatic logic idx_ok(input logic [IDX_W-1:0] idx);
    return int'(idx) < NUM_CORES;
  endfunction

  logic raise_cmd, clear_cmd, raise_ok, clear_ok;

  always_comb begin
    raise_cmd = cmd_valid && (xirq_op_e'(cmd_op) == OP_RAISE);
    clear_cmd = cmd_valid && (xirq_op_e'(cmd_op) == OP_CLEAR);
    self_hit  = raise_cmd && (cmd_param == cmd_core);
    raise_ok  = raise_cmd && !self_hit && idx_ok(cmd_param) && idx_ok(cmd_core);
    clear_ok  = clear_cmd && idx_ok(cmd_param) && idx_ok(cmd_core);
    rd_peek   = cmd_valid && (xirq_op_e'(cmd_op) == OP_PEEK) &&
                idx_ok(cmd_param) && idx_ok(cmd_core);
    rd_who    = cmd_valid && (xirq_op_e'(cmd_op) == OP_WHO) && idx_ok(cmd_core);
  end

  // set_mx[s][t]: the issuer s raises target t.
  // clr_mx[s][t]: target t (the issuer) acknowledges sender s.
  for (genvar s = 0; s < NUM_CORES; s++) begin : g_snd
    for (genvar t = 0; t < NUM_CORES; t++) begin : g_tgt
      assign set_mx[s][t] = raise_ok && (int'(cmd_core) == s) && (int'(cmd_param) == t);
      assign clr_mx[s][t] = clear_ok && (int'(cmd_param) == s) && (int'(cmd_core) == t);
    end
  end
endmodule

// File: rtl/xirq_matrix.sv
module xirq_matrix #(
  parameter int NUM_CORES = 4
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic [NUM_CORES-1:0][NUM_CORES-1:0] set_mx,
  input  logic [NUM_CORES-1:0][NUM_CORES-1:0] clr_mx,
  output logic [NUM_CORES-1:0][NUM_CORES-1:0] pend
);
  // One flag per ordered pair [sender][target]. Only one command is
  // applied per cycle, so a cell never sees set and clear together.
  for (genvar s = 0; s < NUM_CORES; s++) begin : g_snd
    for (genvar t = 0; t < NUM_CORES; t++) begin : g_tgt
      always_ff @(posedge clk) begin
        if (!rst_n)            pend[s][t] <= 1'b0;
        else if (clr_mx[s][t]) pend[s][t] <= 1'b0;
        else if (set_mx[s][t]) pend[s][t] <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/xirq_readback.sv
module xirq_readback #(
  parameter int NUM_CORES = 4,
  parameter int RB_W      = 32,
  parameter int IDX_W     = 2
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic                                rd_peek,
  input  logic                                rd_who,
  input  logic [IDX_W-1:0]                    cmd_param,
  input  logic [IDX_W-1:0]                    cmd_core,
  input  logic [NUM_CORES-1:0][NUM_CORES-1:0] pend,
  output logic [RB_W-1:0]                     readback
);
  // Flag from the issuer toward the named target, zero-extended.
  function automatic logic [RB_W-1:0] peek_word(
    input logic [NUM_CORES-1:0][NUM_CORES-1:0] p,
    input logic [IDX_W-1:0] issuer,
    input logic [IDX_W-1:0] target);
    logic [RB_W-1:0] w;
    w    = '0;
    w[0] = p[issuer][target];
    return w;
  endfunction

  // Bit s is set when sender s has a flag toward the issuer.
  function automatic logic [RB_W-1:0] who_word(
    input logic [NUM_CORES-1:0][NUM_CORES-1:0] p,
    input logic [IDX_W-1:0] issuer);
    logic [RB_W-1:0] w;
    w = '0;
    for (int s = 0; s < NUM_CORES; s++) begin
      if (s < RB_W) w[s] = p[s][issuer];
    end
    return w;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n)       readback <= '0;
    else if (rd_peek) readback <= peek_word(pend, cmd_core, cmd_param);
    else if (rd_who)  readback <= who_word(pend, cmd_core);
  end
endmodule

// File: rtl/xirq_fanin.sv
module xirq_fanin #(
  parameter int NUM_CORES = 4
) (
  input  logic [NUM_CORES-1:0][NUM_CORES-1:0] pend,
  output logic [NUM_CORES-1:0]                irq_out
);
  function automatic logic any_toward(
    input logic [NUM_CORES-1:0][NUM_CORES-1:0] p,
    input int t);
    logic r;
    r = 1'b0;
    for (int s = 0; s < NUM_CORES; s++) r = r | p[s][t];
    return r;
  endfunction

  for (genvar t = 0; t < NUM_CORES; t++) begin : g_line
    assign irq_out[t] = any_toward(pend, t);
  end
endmodule

// File: rtl/xirq_unit.sv
module xirq_unit #(
  parameter int NUM_CORES = 4,
  parameter int RB_W      = 32,
  localparam int IDX_W    = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cmd_valid,
  input  logic [1:0]           cmd_op,
  input  logic [IDX_W-1:0]     cmd_param,
  input  logic [IDX_W-1:0]     cmd_core,
  output logic [RB_W-1:0]      readback,
  output logic [NUM_CORES-1:0] irq_out
);
  logic [NUM_CORES-1:0][NUM_CORES-1:0] set_mx;
  logic [NUM_CORES-1:0][NUM_CORES-1:0] clr_mx;
  logic [NUM_CORES-1:0][NUM_CORES-1:0] pend_q;
  logic rd_peek, rd_who, self_hit;

  xirq_decode #(.NUM_CORES(NUM_CORES), .IDX_W(IDX_W)) u_decode (
    .cmd_valid (cmd_valid),
    .cmd_op    (cmd_op),
    .cmd_param (cmd_param),
    .cmd_core  (cmd_core),
    .set_mx    (set_mx),
    .clr_mx    (clr_mx),
    .rd_peek   (rd_peek),
    .rd_who    (rd_who),
    .self_hit  (self_hit)
  );

  xirq_matrix #(.NUM_CORES(NUM_CORES)) u_matrix (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_mx (set_mx),
    .clr_mx (clr_mx),
    .pend   (pend_q)
  );

  xirq_readback #(.NUM_CORES(NUM_CORES), .RB_W(RB_W), .IDX_W(IDX_W)) u_readback (
    .clk       (clk),
    .rst_n     (rst_n),
    .rd_peek   (rd_peek),
    .rd_who    (rd_who),
    .cmd_param (cmd_param),
    .cmd_core  (cmd_core),
    .pend      (pend_q),
    .readback  (readback)
  );

  xirq_fanin #(.NUM_CORES(NUM_CORES)) u_fanin (
    .pend    (pend_q),
    .irq_out (irq_out)
  );
endmodule

// File: rtl/xirq_unit_chk.sv
module xirq_unit_chk #(
  parameter int NUM_CORES = 4,
  parameter int RB_W      = 32,
  parameter int IDX_W     = 2
) (
  input logic                                clk,
  input logic                                rst_n,
  input logic                                cmd_valid,
  input logic [1:0]                          cmd_op,
  input logic [IDX_W-1:0]                    cmd_param,
  input logic [IDX_W-1:0]                    cmd_core,
  input logic [RB_W-1:0]                     readback,
  input logic [NUM_CORES-1:0]                irq_out,
  input logic [NUM_CORES-1:0][NUM_CORES-1:0] pend,
  input logic                                self_hit
);
  // Copy of last cycle's command and flags, so no $past is read before reset.
  logic                                l_valid;
  logic [1:0]                          l_op;
  logic [IDX_W-1:0]                    l_param, l_core;
  logic [NUM_CORES-1:0][NUM_CORES-1:0] l_pend;
  logic                                l_self;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      l_valid <= 1'b0;
      l_op    <= '0;
      l_param <= '0;
      l_core  <= '0;
      l_pend  <= '0;
      l_self  <= 1'b0;
    end else begin
      l_valid <= cmd_valid;
      l_op    <= cmd_op;
      l_param <= cmd_param;
      l_core  <= cmd_core;
      l_pend  <= pend;
      l_self  <= self_hit;
    end
  end

  function automatic logic [RB_W-1:0] who_of(
    input logic [NUM_CORES-1:0][NUM_CORES-1:0] p,
    input logic [IDX_W-1:0] c);
    logic [RB_W-1:0] w;
    w = '0;
    for (int s = 0; s < NUM_CORES; s++) if (s < RB_W) w[s] = p[s][c];
    return w;
  endfunction

  // R1
  raise_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (l_valid && l_op == 2'd0 && l_param != l_core) |-> pend[l_core][l_param]);

  // R2
  self_raise_inert_chk: assert property (@(posedge clk) disable iff (!rst_n)
    l_self |-> (pend == l_pend));

  // R4
  peek_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (l_valid && l_op == 2'd1) |-> (readback == RB_W'(l_pend[l_core][l_param])));

  // R5
  who_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (l_valid && l_op == 2'd2) |-> (readback == who_of(l_pend, l_core)));

  // R6
  ack_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (l_valid && l_op == 2'd3) |-> !pend[l_param][l_core]);

  // R8
  readback_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(cmd_valid && (cmd_op == 2'd1 || cmd_op == 2'd2)) |=> $stable(readback));

  // R10
  idle_inert_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !l_valid |-> (pend == l_pend));

  for (genvar t = 0; t < NUM_CORES; t++) begin : g_line
    // R7
    irq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_out[t] && !(cmd_valid && cmd_op == 2'd3 && int'(cmd_core) == t))
        |=> irq_out[t]);
    // R7
    irq_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!irq_out[t] && !(cmd_valid && cmd_op == 2'd0 && int'(cmd_param) == t))
        |=> !irq_out[t]);
  end
endmodule

bind xirq_unit xirq_unit_chk #(.NUM_CORES(NUM_CORES), .RB_W(RB_W), .IDX_W(IDX_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cmd_valid (cmd_valid),
  .cmd_op    (cmd_op),
  .cmd_param (cmd_param),
  .cmd_core  (cmd_core),
  .readback  (readback),
  .irq_out   (irq_out),
  .pend      (pend_q),
  .self_hit  (self_hit)
);

// File: tb/xirq_unit_bench.sv
module xirq_unit_bench;
  localparam int N    = 4;
  localparam int RB_W = 32;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          cmd_valid;
  logic [1:0]    cmd_op;
  logic [1:0]    cmd_param;
  logic [1:0]    cmd_core;
  logic [RB_W-1:0] readback;
  logic [N-1:0]  irq_out;

  int  errors = 0;
  int  checks = 0;
  bit  done   = 0;

  bit          m [N][N];    // model flags [sender][target]
  logic [RB_W-1:0] m_rb;

  always #5 clk = ~clk;

  xirq_unit #(.NUM_CORES(N), .RB_W(RB_W)) u_xirq_unit (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_param(cmd_param), .cmd_core(cmd_core),
    .readback(readback), .irq_out(irq_out));

  function automatic logic [N-1:0] exp_lines();
    logic [N-1:0] v = '0;
    for (int t = 0; t < N; t++)
      for (int s = 0; s < N; s++) if (m[s][t]) v[t] = 1'b1;
    return v;
  endfunction

  function automatic logic [RB_W-1:0] exp_sources(input int me);
    logic [RB_W-1:0] v = '0;
    for (int s = 0; s < N; s++) v[s] = m[s][me];
    return v;
  endfunction

  task automatic check(input string tag, input string what,
                       input logic [RB_W-1:0] act, input logic [RB_W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // Drive at a negedge, let the posedge apply it, then check at the next negedge.
  task automatic step(input bit v, input int op, input int p, input int c,
                      input string tag);
    string rtag;
    cmd_valid = v; cmd_op = 2'(op); cmd_param = 2'(p); cmd_core = 2'(c);
    @(negedge clk);
    if (v) begin
      case (op)
        0: if (p != c) m[c][p] = 1'b1;
        1: m_rb = RB_W'(m[c][p]);
        2: m_rb = exp_sources(c);
        default: m[p][c] = 1'b0;
      endcase
    end
    rtag = (v && op == 1) ? "R4" : (v && op == 2) ? "R5" : "R8";
    if (tag != "") rtag = tag;
    check(tag == "" ? "R7" : tag, "irq_out", RB_W'(irq_out), RB_W'(exp_lines()));
    check(rtag, "readback", readback, m_rb);
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5A17_0C3E));
    foreach (m[s, t]) m[s][t] = 1'b0;
    m_rb = '0;
    rst_n = 1'b0; cmd_valid = 0; cmd_op = 0; cmd_param = 0; cmd_core = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R9: reset state
    check("R9", "irq_out", RB_W'(irq_out), '0);
    check("R9", "readback", readback, '0);

    // R1: core 0 raises core 2
    step(1, 0, 2, 0, "R1");
    // R2: core 3 raises itself
    step(1, 0, 3, 3, "R2");
    // R10: valid low with a generate on the bus
    step(0, 0, 1, 3, "R10");
    // R3: repeated raise 1 -> 2, then query sources of core 2
    step(1, 0, 2, 1, "R3");
    step(1, 0, 2, 1, "R3");
    step(1, 2, 0, 2, "R5");          // expect bits 0 and 1
    step(1, 3, 1, 2, "R3");          // ack sender 1
    step(1, 1, 2, 1, "R3");          // sender 1 peeks at 2: clear
    step(1, 3, 0, 2, "R7");          // last ack drops line 2
    // R6: senders 0 and 3 toward 1, ack 0 only
    step(1, 0, 1, 0, "R6");
    step(1, 0, 1, 3, "R6");
    step(1, 3, 0, 1, "R6");
    step(1, 2, 0, 1, "R6");          // expect 4'b1000
    step(1, 1, 1, 3, "R4");          // 3 -> 1 still pending
    step(0, 2, 0, 0, "R8");
    step(1, 0, 0, 2, "R8");
    step(1, 3, 3, 1, "R7");

    // Random mix
    for (int i = 0; i < 3000; i++) begin
      int v  = ($urandom % 8) != 0;
      int op = $urandom % 4;
      int p  = $urandom % N;
      int c  = $urandom % N;
      step(v, op, p, c, "");
    end

    // R9: reset again clears everything
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    foreach (m[s, t]) m[s][t] = 1'b0;
    m_rb = '0;
    check("R9", "irq_out", RB_W'(irq_out), '0);
    check("R9", "readback", readback, '0);

    done = 1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule